// File: doc/BRIEF.md
# Double-Buffered OUT Endpoint Controller

This block controls one OUT endpoint of a device-side serial bus controller. A receive front end reports each finished packet with a pulse. The pulse carries the packet's byte length, its data toggle and a flag for a CRC or bit-stuff error. For each packet the controller decides whether to store it, refuse it with NAK or answer with STALL. It then returns the chosen handshake one cycle later. Packet storage is modelled as one or two slots, each holding the length and the error flag of one packet. The buffer RAM itself lies outside the block. The block provides the read offset that a RAM would use to address the next byte.

Firmware sees these outputs: a packet-ready flag, a full flag, a sticky overrun flag, a data-error flag, a sticky stall-sent flag and the 11-bit length of the packet at the head of the queue. Firmware unloads the packet one byte per read strobe. It then releases the packet with a clear or a flush command. Firmware can also hold the endpoint in stall and reset the expected data toggle. In isochronous mode there is no handshake and no toggle check. A packet that finds no free slot in that mode raises overrun instead of being refused.

Top module: `out_ep_ctrl`

## Requirements
- R1: In bulk mode, a packet that passes all checks is stored; it has no error flag, the endpoint is not stalled, a slot is free and its toggle equals the expected toggle. The handshake is ACK, packet-ready rises, byteCnt shows its length, irq pulses for one cycle and the expected toggle flips.
- R2: Capacity is one packet with cfgDouble low and two with it high. fifoFull is high while the number of held packets equals the capacity. Fullness is judged on the state at the start of the cycle, so a release in the same cycle as an arrival does not make room for it.
- R3: In bulk mode, a packet that arrives while fifoFull is high is answered with NAK and not stored.
- R4: In bulk mode, a packet with the wrong data toggle is answered with ACK but discarded, and the expected toggle is left unchanged.
- R5: Packets leave in arrival order. Each fwClear or fwFlush pulse releases only the head packet, so two pulses are needed to empty two queued packets. byteCnt then shows the length of the next packet.
- R6: With cfgAutoClear high, reading the last byte of a packet whose length equals cfgMaxUnits*8 releases it without a command. A shorter packet stays ready after being fully read.
- R7: In isochronous mode, no handshake is returned and no toggle check is made. A packet that finds fifoFull high is dropped and sets overrun. Overrun stays set until a cmdClrOverrun pulse.
- R8: In isochronous mode, a stored packet whose error flag was set raises dataError together with packet-ready. dataError falls when that packet is released.
- R9: In bulk mode with cmdSendStall high, every packet is answered with STALL and not stored. Each STALL sets stallSent and pulses irq. stallSent stays set until a cmdClrStallSent pulse.
- R10: A cmdClrToggle pulse sets the expected data toggle to DATA0 (rxToggle value 0).
- R11: In bulk mode, a packet flagged with a CRC or bit-stuff error gets no handshake and changes no state.
- R12: rdOffset counts the bytes read from the head packet and stops at its length. It returns to 0 when the packet is released.
- R13: hsValid pulses in the cycle after rxValid, and only for bulk packets that get a handshake. hsCode encodings: ACK=0, NAK=1, STALL=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgIso | input | 1 | 1 = isochronous, 0 = bulk/interrupt |
| cfgDouble | input | 1 | Enables the second packet slot |
| cfgAutoClear | input | 1 | Release max-size packets when fully read |
| cfgMaxUnits | input | 8 | Maximum packet size in units of 8 bytes |
| cmdSendStall | input | 1 | Level: answer bulk packets with STALL |
| rxValid | input | 1 | One-cycle pulse: a packet has been received |
| rxLen | input | 11 | Byte length of the received packet |
| rxErr | input | 1 | Packet had a CRC or bit-stuff error |
| rxToggle | input | 1 | Data toggle of the packet (0 = DATA0) |
| hsValid | output | 1 | Handshake is to be sent |
| hsCode | output | 2 | Handshake: 0 ACK, 1 NAK, 2 STALL |
| fwRead | input | 1 | Unload one byte from the head packet |
| fwClear | input | 1 | Release the head packet after reading |
| fwFlush | input | 1 | Discard the head packet |
| cmdClrStallSent | input | 1 | Clear stallSent |
| cmdClrOverrun | input | 1 | Clear overrun |
| cmdClrToggle | input | 1 | Reset the expected toggle to DATA0 |
| pktReady | output | 1 | A packet is waiting to be read |
| fifoFull | output | 1 | No more packets can be accepted |
| overrun | output | 1 | Sticky: isochronous packet dropped |
| dataError | output | 1 | Head isochronous packet had an error |
| stallSent | output | 1 | Sticky: a STALL was sent |
| byteCnt | output | 11 | Length of the head packet, valid with pktReady |
| rdOffset | output | 11 | Offset of the next byte to unload |
| irq | output | 1 | One-cycle pulse on store or STALL |

## Verification
A packet can arrive in the same cycle that firmware releases the head packet. That is where the queue's counters and pointers are most likely to diverge. The bench fills both slots and then raises rxValid and fwClear on the same edge. It expects a NAK from the scoreboard, packet-ready still set, byteCnt moved on to the second packet and fifoFull low. A following packet must then be stored behind that packet.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;

  typedef enum logic [1:0] {
    HS_ACK   = 2'd0,
    HS_NAK   = 2'd1,
    HS_STALL = 2'd2
  } hsKind_e;

  // strobes from control to the slot datapath
  typedef struct packed {
    logic store;     // write the arriving packet into the tail slot
    logic storeErr;  // error flag to keep with it
    logic pop;       // release the head slot
    logic readByte;  // advance the read offset
  } ctrlStrobes_t;

endpackage

// File: rtl/out_ep_slots.sv
module out_ep_slots
  import out_ep_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int LEN_W     = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [LEN_W-1:0] rxLen,
  input  logic             cfgDouble,
  output logic             pktReady,
  output logic             fifoFull,
  output logic             headErr,
  output logic [LEN_W-1:0] headLen,
  output logic [LEN_W-1:0] rdOffset
);
  localparam int PTR_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int CNT_W = $clog2(NUM_SLOTS + 1);

  logic [PTR_W-1:0]             headPtr, tailPtr;
  logic [CNT_W-1:0]             used;
  logic [CNT_W-1:0]             capacity;
  logic [NUM_SLOTS-1:0][LEN_W-1:0] lenQ;
  logic [NUM_SLOTS-1:0]         errQ;
  logic [NUM_SLOTS-1:0]         slotHit;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLOTS; gi++) begin : gSlot
      assign slotHit[gi] = strb.store && (tailPtr == PTR_W'(gi));
    end
  endgenerate

  assign capacity = cfgDouble ? CNT_W'(NUM_SLOTS) : CNT_W'(1);
  assign pktReady = (used != '0);
  assign fifoFull = (used >= capacity);
  assign headLen  = lenQ[headPtr];
  assign headErr  = errQ[headPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      used     <= '0;
      rdOffset <= '0;
      lenQ     <= '0;
      errQ     <= '0;
    end else begin
      if (strb.store) tailPtr <= advance(tailPtr);
      if (strb.pop)   headPtr <= advance(headPtr);
      used <= used + CNT_W'(strb.store) - CNT_W'(strb.pop);
      if (strb.pop)           rdOffset <= '0;
      else if (strb.readByte) rdOffset <= rdOffset + 1'b1;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (slotHit[i]) begin
          lenQ[i] <= rxLen;
          errQ[i] <= strb.storeErr;
        end
      end
    end
  end

endmodule

// File: rtl/out_ep_ctrl_fsm.sv
module out_ep_ctrl_fsm
  import out_ep_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int MAX_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgIso,
  input  logic             cfgAutoClear,
  input  logic [MAX_W-1:0] cfgMaxUnits,
  input  logic             cmdSendStall,
  input  logic             rxValid,
  input  logic             rxErr,
  input  logic             rxToggle,
  input  logic             fwRead,
  input  logic             fwClear,
  input  logic             fwFlush,
  input  logic             cmdClrStallSent,
  input  logic             cmdClrOverrun,
  input  logic             cmdClrToggle,
  input  logic             pktReady,
  input  logic             fifoFull,
  input  logic [LEN_W-1:0] headLen,
  input  logic [LEN_W-1:0] rdOffset,
  output ctrlStrobes_t     strb,
  output logic             hsValid,
  output logic [1:0]       hsCode,
  output logic             overrun,
  output logic             stallSent,
  output logic             irq
);
  localparam int UNIT_SHIFT = 3;

  logic [LEN_W-1:0] maxBytes;
  logic             expToggle;
  logic             flip, hsFire, setOver, sendStall, lastByte, autoDone;
  hsKind_e          hsNext;

  assign maxBytes = LEN_W'({cfgMaxUnits, UNIT_SHIFT'(0)});

  always_comb begin
    strb      = '0;
    hsNext    = HS_ACK;
    hsFire    = 1'b0;
    setOver   = 1'b0;
    sendStall = 1'b0;
    flip      = 1'b0;

    strb.readByte = fwRead && pktReady && (rdOffset < headLen);
    lastByte      = strb.readByte && (rdOffset == headLen - 1'b1);
    autoDone      = cfgAutoClear && lastByte && (headLen == maxBytes);
    strb.pop      = pktReady && (fwClear || fwFlush || autoDone);
    strb.storeErr = rxErr;

    if (rxValid) begin
      if (cfgIso) begin
        if (fifoFull) setOver = 1'b1;
        else          strb.store = 1'b1;
      end else if (cmdSendStall) begin
        hsFire    = 1'b1;
        hsNext    = HS_STALL;
        sendStall = 1'b1;
      end else if (!rxErr) begin
        hsFire = 1'b1;
        if (fifoFull) begin
          hsNext = HS_NAK;
        end else if (rxToggle == expToggle) begin
          strb.store = 1'b1;
          flip       = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expToggle <= 1'b0;
      overrun   <= 1'b0;
      stallSent <= 1'b0;
      hsValid   <= 1'b0;
      hsCode    <= HS_ACK;
      irq       <= 1'b0;
    end else begin
      if (cmdClrToggle) expToggle <= 1'b0;
      else if (flip)    expToggle <= ~expToggle;
      if (setOver)            overrun <= 1'b1;
      else if (cmdClrOverrun) overrun <= 1'b0;
      if (sendStall)            stallSent <= 1'b1;
      else if (cmdClrStallSent) stallSent <= 1'b0;
      hsValid <= hsFire;
      hsCode  <= hsNext;
      irq     <= strb.store || sendStall;
    end
  end

endmodule

// File: rtl/out_ep_ctrl.sv
module out_ep_ctrl
  import out_ep_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int LEN_W     = 11,
  parameter int MAX_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgIso,
  input  logic             cfgDouble,
  input  logic             cfgAutoClear,
  input  logic [MAX_W-1:0] cfgMaxUnits,
  input  logic             cmdSendStall,
  input  logic             rxValid,
  input  logic [LEN_W-1:0] rxLen,
  input  logic             rxErr,
  input  logic             rxToggle,
  output logic             hsValid,
  output logic [1:0]       hsCode,
  input  logic             fwRead,
  input  logic             fwClear,
  input  logic             fwFlush,
  input  logic             cmdClrStallSent,
  input  logic             cmdClrOverrun,
  input  logic             cmdClrToggle,
  output logic             pktReady,
  output logic             fifoFull,
  output logic             overrun,
  output logic             dataError,
  output logic             stallSent,
  output logic [LEN_W-1:0] byteCnt,
  output logic [LEN_W-1:0] rdOffset,
  output logic             irq
);
  ctrlStrobes_t strb;
  logic         headErr;

  out_ep_ctrl_fsm #(.LEN_W(LEN_W), .MAX_W(MAX_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgIso(cfgIso), .cfgAutoClear(cfgAutoClear),
    .cfgMaxUnits(cfgMaxUnits), .cmdSendStall(cmdSendStall),
    .rxValid(rxValid), .rxErr(rxErr), .rxToggle(rxToggle),
    .fwRead(fwRead), .fwClear(fwClear), .fwFlush(fwFlush),
    .cmdClrStallSent(cmdClrStallSent), .cmdClrOverrun(cmdClrOverrun),
    .cmdClrToggle(cmdClrToggle), .pktReady(pktReady), .fifoFull(fifoFull),
    .headLen(byteCnt), .rdOffset(rdOffset), .strb(strb),
    .hsValid(hsValid), .hsCode(hsCode), .overrun(overrun),
    .stallSent(stallSent), .irq(irq)
  );

  out_ep_slots #(.NUM_SLOTS(NUM_SLOTS), .LEN_W(LEN_W)) uSlots (
    .clk(clk), .rstN(rstN), .strb(strb), .rxLen(rxLen), .cfgDouble(cfgDouble),
    .pktReady(pktReady), .fifoFull(fifoFull), .headErr(headErr),
    .headLen(byteCnt), .rdOffset(rdOffset)
  );

  assign dataError = pktReady && headErr;

endmodule

// File: rtl/out_ep_ctrl_chk.sv
module out_ep_ctrl_chk #(
  parameter int LEN_W = 11,
  parameter int MAX_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgIso,
  input logic             cmdSendStall,
  input logic             cmdClrOverrun,
  input logic             rxValid,
  input logic             rxErr,
  input logic             hsValid,
  input logic [1:0]       hsCode,
  input logic             pktReady,
  input logic             fifoFull,
  input logic             overrun,
  input logic             dataError,
  input logic             stallSent,
  input logic [LEN_W-1:0] byteCnt,
  input logic [LEN_W-1:0] rdOffset
);
  AST_FULL_NAK: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !cfgIso && !cmdSendStall && !rxErr && fifoFull |=> hsValid && hsCode == 2'd1); // R3

  AST_STALL_SENT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !cfgIso && cmdSendStall |=> hsValid && hsCode == 2'd2 && stallSent); // R9

  AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !cmdClrOverrun |=> overrun); // R7

  AST_ISO_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && cfgIso |=> !hsValid); // R7

  AST_DERR_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rstN)
    dataError |-> pktReady); // R8

  AST_FULL_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> pktReady); // R2

  AST_HS_AFTER_RX: assert property (@(posedge clk) disable iff (!rstN)
    hsValid |-> $past(rxValid)); // R13

  AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pktReady |-> rdOffset <= byteCnt); // R12
endmodule

bind out_ep_ctrl out_ep_ctrl_chk #(.LEN_W(LEN_W), .MAX_W(MAX_W)) uChk (.*);

// File: tb/out_ep_ctrl_test.sv
module out_ep_ctrl_test;
  localparam int LEN_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgIso = 1'b0, cfgDouble = 1'b0, cfgAutoClear = 1'b0;
  logic [7:0] cfgMaxUnits = 8'd2;
  logic cmdSendStall = 1'b0;
  logic rxValid = 1'b0, rxErr = 1'b0, rxToggle = 1'b0;
  logic [LEN_W-1:0] rxLen = '0;
  logic hsValid;
  logic [1:0] hsCode;
  logic fwRead = 1'b0, fwClear = 1'b0, fwFlush = 1'b0;
  logic cmdClrStallSent = 1'b0, cmdClrOverrun = 1'b0, cmdClrToggle = 1'b0;
  logic pktReady, fifoFull, overrun, dataError, stallSent, irq;
  logic [LEN_W-1:0] byteCnt, rdOffset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int expQ[$];

  always #4 clk = ~clk;

  out_ep_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgIso(cfgIso), .cfgDouble(cfgDouble),
    .cfgAutoClear(cfgAutoClear), .cfgMaxUnits(cfgMaxUnits),
    .cmdSendStall(cmdSendStall), .rxValid(rxValid), .rxLen(rxLen),
    .rxErr(rxErr), .rxToggle(rxToggle), .hsValid(hsValid), .hsCode(hsCode),
    .fwRead(fwRead), .fwClear(fwClear), .fwFlush(fwFlush),
    .cmdClrStallSent(cmdClrStallSent), .cmdClrOverrun(cmdClrOverrun),
    .cmdClrToggle(cmdClrToggle), .pktReady(pktReady), .fifoFull(fifoFull),
    .overrun(overrun), .dataError(dataError), .stallSent(stallSent),
    .byteCnt(byteCnt), .rdOffset(rdOffset), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: every handshake must match the oldest expected one (R13)
  always @(negedge clk) begin
    if (rstN && hsValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R13: actual handshake %0d expected none", hsCode);
      end else begin
        int e;
        e = expQ.pop_front();
        if (int'(hsCode) != e) begin
          errors++;
          $display("FAIL R13: actual handshake %0d expected %0d", hsCode, e);
        end
      end
    end
  end

  // driver: one packet; expHs < 0 means no handshake expected
  task automatic sendPkt(input int len, input bit tog, input bit err,
                         input int expHs, input bit withClr);
    @(negedge clk);
    rxValid = 1'b1; rxLen = LEN_W'(len); rxToggle = tog; rxErr = err;
    fwClear = withClr;
    if (expHs >= 0) expQ.push_back(expHs);
    @(negedge clk);
    rxValid = 1'b0; rxErr = 1'b0; fwClear = 1'b0;
  endtask

  task automatic readBytes(input int n);
    @(negedge clk);
    fwRead = 1'b1;
    repeat (n) @(negedge clk);
    fwRead = 1'b0;
  endtask

  task automatic cmd(input int which);
    @(negedge clk);
    case (which)
      0: fwClear = 1'b1;
      1: fwFlush = 1'b1;
      2: cmdClrToggle = 1'b1;
      3: cmdClrOverrun = 1'b1;
      default: cmdClrStallSent = 1'b1;
    endcase
    @(negedge clk);
    fwClear = 1'b0; fwFlush = 1'b0; cmdClrToggle = 1'b0;
    cmdClrOverrun = 1'b0; cmdClrStallSent = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset pktReady", pktReady, 0);
    check("R2 reset fifoFull", fifoFull, 0);
    check("R7 reset overrun", overrun, 0);
    check("R9 reset stallSent", stallSent, 0);
    check("R13 reset hsValid", hsValid, 0);

    // single slot, bulk
    sendPkt(10, 0, 0, 0, 0);
    check("R1 pktReady", pktReady, 1);
    check("R1 byteCnt", byteCnt, 10);
    check("R1 irq", irq, 1);
    check("R2 single full", fifoFull, 1);
    sendPkt(5, 1, 0, 1, 0);
    check("R3 NAK not stored", byteCnt, 10);
    readBytes(3);
    check("R12 offset 3", rdOffset, 3);
    readBytes(20);
    check("R12 offset capped", rdOffset, 10);
    cmd(0);
    check("R5 cleared", pktReady, 0);
    check("R12 offset reset", rdOffset, 0);

    // expected toggle is now 1
    sendPkt(7, 0, 0, 0, 0);
    check("R4 wrong toggle dropped", pktReady, 0);
    sendPkt(7, 1, 0, 0, 0);
    check("R4 toggle unchanged", pktReady, 1);
    check("R1 byteCnt 7", byteCnt, 7);
    cmd(0);
    sendPkt(2, 0, 0, 0, 0);   // expected becomes 1
    cmd(0);
    cmd(2);                   // R10 back to DATA0
    sendPkt(4, 1, 0, 0, 0);
    check("R10 DATA1 rejected", pktReady, 0);
    sendPkt(4, 0, 0, 0, 0);
    check("R10 DATA0 accepted", pktReady, 1);
    cmd(0);

    // double slot, expected toggle 1
    cfgDouble = 1'b1;
    sendPkt(16, 1, 0, 0, 0);
    check("R2 double one held", fifoFull, 0);
    sendPkt(4, 0, 0, 0, 0);
    check("R2 double full", fifoFull, 1);
    check("R5 head first", byteCnt, 16);
    cmd(1);
    check("R5 flush one", pktReady, 1);
    check("R5 next length", byteCnt, 4);
    cmd(1);
    check("R5 flush two", pktReady, 0);

    // auto-clear, max size 16
    cfgAutoClear = 1'b1;
    sendPkt(16, 1, 0, 0, 0);
    readBytes(15);
    check("R6 not yet", pktReady, 1);
    readBytes(1);
    check("R6 auto released", pktReady, 0);
    check("R12 offset after auto", rdOffset, 0);
    sendPkt(8, 0, 0, 0, 0);
    readBytes(8);
    check("R6 short stays", pktReady, 1);
    cmd(0);
    cfgAutoClear = 1'b0;

    // same-cycle arrival and release, expected toggle 1
    sendPkt(3, 1, 0, 0, 0);
    sendPkt(5, 0, 0, 0, 0);
    sendPkt(9, 1, 0, 1, 1);
    check("R2 collide ready", pktReady, 1);
    check("R2 collide head", byteCnt, 5);
    check("R2 collide full", fifoFull, 0);
    sendPkt(9, 1, 0, 0, 0);
    check("R2 refill full", fifoFull, 1);
    check("R5 order kept", byteCnt, 5);
    cmd(0);
    check("R5 second", byteCnt, 9);
    cmd(0);

    // error packet in bulk mode, expected toggle 0
    sendPkt(6, 0, 1, -1, 0);
    check("R11 ignored", pktReady, 0);
    sendPkt(6, 0, 0, 0, 0);
    check("R11 toggle kept", byteCnt, 6);
    cmd(0);

    // stall
    cmdSendStall = 1'b1;
    sendPkt(6, 1, 0, 2, 0);
    check("R9 stallSent", stallSent, 1);
    check("R9 irq", irq, 1);
    check("R9 not stored", pktReady, 0);
    cmdSendStall = 1'b0;
    @(negedge clk);
    check("R9 sticky", stallSent, 1);
    cmd(4);
    check("R9 cleared", stallSent, 0);

    // isochronous, single slot
    cfgIso = 1'b1; cfgDouble = 1'b0;
    sendPkt(12, 0, 1, -1, 0);
    check("R8 ready", pktReady, 1);
    check("R8 dataError", dataError, 1);
    check("R7 no toggle check irq", irq, 1);
    sendPkt(5, 1, 0, -1, 0);
    check("R7 overrun", overrun, 1);
    check("R7 dropped", byteCnt, 12);
    cmd(0);
    check("R8 error cleared", dataError, 0);
    sendPkt(3, 0, 0, -1, 0);
    check("R8 clean packet", dataError, 0);
    check("R7 overrun sticky", overrun, 1);
    cmd(3);
    check("R7 overrun cleared", overrun, 0);
    cmd(0);

    repeat (2) @(negedge clk);
    check("R13 all handshakes seen", expQ.size(), 0);
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule